// File: doc/BRIEF.md
# Reset cause and status controller

This block sequences the core reset of a small 8-bit microcontroller and keeps its 8-bit status register. It accepts a power-on pulse, an active-low external clear pin, a watchdog timeout pulse, and two strobes from the core: one for sleep entry and one for watchdog clear. It works out which of five restart kinds has happened and records that in two flag bits, timeout (bit 4) and power-down (bit 3). Software can read these bits after a restart to find its cause.

The status layout is: bits 7..5 page select, bit 4 timeout, bit 3 power-down, bit 2 zero, bit 1 digit-carry, bit 0 carry. The external clear pin and the watchdog pulse are asynchronous and pass through a synchroniser of `SYNC_STAGES` flops (default 2). A restart is taken on the rising edge of the synchronised request. The power-on pulse is synchronous and is used directly. The core reset output is held for `HOLD_CYCLES` clocks (default 4) after the last active request is sampled.

A wake from sleep through the clear pin or the watchdog always runs a full core reset. Execution never resumes where it stopped.

Top module: `rstc_ctrl`

## Requirements
- R1: While `por_i` is high, the next clock gives status 0x18 (page 0, timeout 1, power-down 1, low bits 0), sleeping 0 and core reset 1. Core reset falls HOLD_CYCLES clocks after `por_i` is sampled low.
- R2: A clear-pin restart while awake clears bits 7..5 and leaves bits 4..0 unchanged.
- R3: A clear-pin restart while sleeping clears bits 7..5, sets timeout to 1, clears power-down to 0 and keeps bits 2..0.
- R4: A watchdog restart while awake clears bits 7..5, clears timeout to 0, sets power-down to 1 and keeps bits 2..0.
- R5: A watchdog restart while sleeping clears bits 7..5, clears timeout and power-down to 0 and keeps bits 2..0.
- R6: When requests are seen together, power-on wins over the clear pin, and the clear pin wins over the watchdog. A request that loses is discarded.
- R7: A sleep strobe sets sleeping, sets timeout to 1 and clears power-down to 0. A watchdog-clear strobe sets both flags to 1. If both strobes come in the same cycle, the sleep strobe wins. Neither strobe changes bits 7..5 or 2..0.
- R8: A clear-pin or watchdog request while sleeping raises core reset and clears sleeping.
- R9: A core write (`wr_en_i`) loads bits 7..5 and 2..0 from `wr_data_i`. Timeout and power-down never change on a write.
- R10: While core reset is high or the block is sleeping, writes and strobes have no effect.
- R11: Core reset falls SYNC_STAGES+HOLD_CYCLES clocks after the clear pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on request, synchronous, active high |
| clr_n_i | input | 1 | External clear pin, asynchronous, active low |
| wdt_to_i | input | 1 | Watchdog timeout pulse, asynchronous |
| sleep_i | input | 1 | Sleep-entry strobe from the core |
| wdt_clr_i | input | 1 | Watchdog-clear strobe from the core |
| wr_en_i | input | 1 | Status write enable |
| wr_data_i | input | 8 | Status write data |
| core_rst_o | output | 1 | Synchronous core reset |
| sleeping_o | output | 1 | Core is sleeping |
| status_o | output | 8 | Status register value |

## Verification
The bench goes after these corner cases and the fault each one would expose:
- **Sleep state during a restart.** A clear pin or watchdog is applied while sleeping and while awake. A design that ignored the sleep state would leave identical flag patterns for the two cases.
- **Simultaneous requests.** Clear and watchdog arrive in the same cycle, and power-on overlaps a clear or watchdog. A wrong priority would show a watchdog flag pattern or non-zero page bits after power-on.
- **Writes and strobes that must have no effect.** Writes are tried on the read-only flags, while sleeping and during core reset. A leaky write path would change bits the bench then reads back.
- **Reset release timing.** The release is counted in clocks after power-on and after the clear pin. An off-by-one in the hold counter or the synchroniser would move the falling edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef struct packed {
        logic [2:0] page;
        logic       to;
        logic       pd;
        logic       z;
        logic       dc;
        logic       c;
    } stat_t;

    typedef enum logic [2:0] {
        RK_NONE    = 3'd0,
        RK_POR     = 3'd1,
        RK_CLR_RUN = 3'd2,
        RK_CLR_SLP = 3'd3,
        RK_WDT_RUN = 3'd4,
        RK_WDT_SLP = 3'd5
    } rkind_t;

    // Power-on beats clear pin beats watchdog.
    function automatic rkind_t classify(input logic por, input logic clr_ev,
                                        input logic wdt_ev, input logic slp);
        rkind_t k;
        if (por)         k = RK_POR;
        else if (clr_ev) k = slp ? RK_CLR_SLP : RK_CLR_RUN;
        else if (wdt_ev) k = slp ? RK_WDT_SLP : RK_WDT_RUN;
        else             k = RK_NONE;
        return k;
    endfunction

    function automatic stat_t apply_reset(input rkind_t k, input stat_t s);
        stat_t n;
        n = s;
        n.page = 3'b000;
        case (k)
            RK_POR: begin
                n = '0;
                n.to = 1'b1;
                n.pd = 1'b1;
            end
            RK_CLR_SLP: begin n.to = 1'b1; n.pd = 1'b0; end
            RK_WDT_RUN: begin n.to = 1'b0; n.pd = 1'b1; end
            RK_WDT_SLP: begin n.to = 1'b0; n.pd = 1'b0; end
            RK_CLR_RUN: ;
            default:    n = s;
        endcase
        return n;
    endfunction

    function automatic stat_t apply_core(input stat_t s, input logic slp_stb,
                                         input logic wclr_stb, input logic wr,
                                         input logic [2:0] wr_page,
                                         input logic [2:0] wr_low);
        stat_t n;
        n = s;
        if (wr) begin
            n.page = wr_page;
            {n.z, n.dc, n.c} = wr_low;
        end
        if (slp_stb) begin
            n.to = 1'b1;
            n.pd = 1'b0;
        end else if (wclr_stb) begin
            n.to = 1'b1;
            n.pd = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] ff_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) ff_q[0] <= d_i;
        end else begin : g_next
            always_ff @(posedge clk) ff_q[g] <= ff_q[g-1];
        end
    end

    assign q_o = ff_q[LAST];
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
    import rstc_pkg::*;
(
    input  logic   clk,
    input  logic   por_i,
    input  logic   clr_req_i,
    input  logic   wdt_req_i,
    input  logic   sleeping_i,
    output rkind_t kind_o
);
    logic clr_prev_q;
    logic wdt_prev_q;

    always_ff @(posedge clk) begin
        clr_prev_q <= clr_req_i;
        wdt_prev_q <= wdt_req_i;
    end

    assign kind_o = classify(por_i,
                             clr_req_i & ~clr_prev_q,
                             wdt_req_i & ~wdt_prev_q,
                             sleeping_i);
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
    parameter int unsigned HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic src_i,
    output logic busy_o
);
    localparam int unsigned    CW   = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0]  LOAD = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (src_i)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rstc_status.sv
module rstc_status
    import rstc_pkg::*;
(
    input  logic       clk,
    input  rkind_t     kind_i,
    input  logic       core_busy_i,
    input  logic       sleep_i,
    input  logic       wdt_clr_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output stat_t      stat_o,
    output logic       sleeping_o
);
    stat_t st_q;
    logic  slp_q;
    logic  unused_ro;

    // Write data bits 4..3 land on read-only flags.
    assign unused_ro = ^wr_data_i[4:3];

    always_ff @(posedge clk) begin
        if (kind_i != RK_NONE) begin
            st_q  <= apply_reset(kind_i, st_q);
            slp_q <= 1'b0;
        end else if (!core_busy_i && !slp_q) begin
            st_q <= apply_core(st_q, sleep_i, wdt_clr_i, wr_en_i,
                               wr_data_i[7:5], wr_data_i[2:0]);
            if (sleep_i)
                slp_q <= 1'b1;
        end
    end

    assign stat_o     = st_q;
    assign sleeping_o = slp_q;
endmodule

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CYCLES = 4
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       clr_n_i,
    input  logic       wdt_to_i,
    input  logic       sleep_i,
    input  logic       wdt_clr_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic       core_rst_o,
    output logic       sleeping_o,
    output logic [7:0] status_o
);
    logic   clr_req;
    logic   wdt_req;
    logic   src_any;
    logic   busy;
    rkind_t cause_kind;
    stat_t  stat;

    rstc_sync #(.STAGES(SYNC_STAGES)) u_sync_clr (
        .clk (clk),
        .d_i (~clr_n_i),
        .q_o (clr_req)
    );

    rstc_sync #(.STAGES(SYNC_STAGES)) u_sync_wdt (
        .clk (clk),
        .d_i (wdt_to_i),
        .q_o (wdt_req)
    );

    rstc_cause u_cause (
        .clk        (clk),
        .por_i      (por_i),
        .clr_req_i  (clr_req),
        .wdt_req_i  (wdt_req),
        .sleeping_i (sleeping_o),
        .kind_o     (cause_kind)
    );

    assign src_any = por_i | clr_req | wdt_req;

    rstc_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .src_i  (src_any),
        .busy_o (busy)
    );

    rstc_status u_status (
        .clk         (clk),
        .kind_i      (cause_kind),
        .core_busy_i (busy),
        .sleep_i     (sleep_i),
        .wdt_clr_i   (wdt_clr_i),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .stat_o      (stat),
        .sleeping_o  (sleeping_o)
    );

    assign core_rst_o = busy;
    assign status_o   = stat;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
(
    input logic       clk,
    input logic       por_i,
    input logic       sleep_i,
    input logic       wdt_clr_i,
    input rkind_t     kind,
    input logic       core_rst_o,
    input logic       sleeping_o,
    input logic [7:0] status_o
);
    logic seen_por;

    always_ff @(posedge clk)
        if (por_i) seen_por <= 1'b1;

    // R1
    a_r1_por_state: assert property (@(posedge clk) disable iff (!seen_por)
        por_i |=> (status_o == 8'h18) && !sleeping_o && core_rst_o);

    // R4
    a_r4_wdt_run_flags: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_WDT_RUN) |=> (status_o[4:3] == 2'b01) && (status_o[7:5] == 3'b000));

    // R5
    a_r5_wdt_slp_flags: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_WDT_SLP) |=> (status_o[4:3] == 2'b00));

    // R3
    a_r3_clr_slp_flags: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_CLR_SLP) |=> (status_o[4:3] == 2'b10));

    // R8
    a_r8_wake_resets: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_CLR_SLP || kind == RK_WDT_SLP) |=> core_rst_o && !sleeping_o);

    // R7
    a_r7_sleep_entry: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_NONE && !core_rst_o && !sleeping_o && sleep_i)
        |=> sleeping_o && (status_o[4:3] == 2'b10));

    // R9
    a_r9_flags_readonly: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_NONE && !sleep_i && !wdt_clr_i) |=> $stable(status_o[4:3]));

    // R10
    a_r10_sleep_frozen: assert property (@(posedge clk) disable iff (por_i || !seen_por)
        (kind == RK_NONE && sleeping_o) |=> $stable(status_o) && sleeping_o);
endmodule

bind rstc_ctrl rstc_checker u_chk (
    .clk        (clk),
    .por_i      (por_i),
    .sleep_i    (sleep_i),
    .wdt_clr_i  (wdt_clr_i),
    .kind       (cause_kind),
    .core_rst_o (core_rst_o),
    .sleeping_o (sleeping_o),
    .status_o   (status_o)
);

// File: tb/rstc_ctrl_tb_top.sv
module rstc_ctrl_tb_top;
    localparam int SYNC = 2;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       por_i = 1'b0;
    logic       clr_n_i = 1'b1;
    logic       wdt_to_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       wdt_clr_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       core_rst_o;
    logic       sleeping_o;
    logic [7:0] status_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m;
    logic       ms;

    always #5 clk = ~clk;

    rstc_ctrl #(.SYNC_STAGES(SYNC), .HOLD_CYCLES(HOLD)) dut_i (
        .clk(clk), .por_i(por_i), .clr_n_i(clr_n_i), .wdt_to_i(wdt_to_i),
        .sleep_i(sleep_i), .wdt_clr_i(wdt_clr_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .core_rst_o(core_rst_o),
        .sleeping_o(sleeping_o), .status_o(status_o)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_state(input string req);
        check(status_o == m, req, status_o, m);
        check(sleeping_o == ms, {req, " sleeping"}, sleeping_o, ms);
        check(core_rst_o == 1'b0, {req, " core_rst idle"}, core_rst_o, 0);
    endtask

    // kind: 1 clear pin, 2 watchdog
    function automatic logic [7:0] model_rst(input logic [7:0] s, input int kind, input logic slp);
        logic [7:0] n;
        n = {3'b000, s[4:0]};
        if (kind == 1 && slp)      n[4:3] = 2'b10;
        else if (kind == 2 && slp) n[4:3] = 2'b00;
        else if (kind == 2)        n[4:3] = 2'b01;
        return n;
    endfunction

    task automatic measure_hold(input int exp, input string req);
        int n = 0;
        do begin
            tick();
            n++;
        end while (core_rst_o && n < 50);
        check(n == exp, req, n, exp);
    endtask

    task automatic do_por(input int len);
        por_i = 1'b1;
        repeat (len) tick();
        check(core_rst_o == 1'b1, "R1 core_rst during por", core_rst_o, 1);
        check(status_o == 8'h18, "R1 status during por", status_o, 8'h18);
        por_i = 1'b0;
        m = 8'h18;
        ms = 1'b0;
        measure_hold(HOLD, "R1 release after por");
        chk_state("R1 after por");
    endtask

    task automatic do_clr(input int len, input logic wr_mid, input string req);
        m = model_rst(m, 1, ms);
        clr_n_i = 1'b0;
        repeat (3) tick();
        check(core_rst_o == 1'b1, {req, " R8 core_rst raised"}, core_rst_o, 1);
        check(sleeping_o == 1'b0, {req, " R8 sleeping cleared"}, sleeping_o, 0);
        ms = 1'b0;
        if (wr_mid) begin
            // R10: write while core reset is high
            wr_en_i = 1'b1; wr_data_i = 8'hFF; sleep_i = 1'b1;
            tick();
            wr_en_i = 1'b0; sleep_i = 1'b0;
        end
        repeat (len - 3) tick();
        clr_n_i = 1'b1;
        measure_hold(SYNC + HOLD, "R11 release after clear pin");
        chk_state(req);
    endtask

    task automatic do_wdt(input string req);
        m = model_rst(m, 2, ms);
        wdt_to_i = 1'b1;
        tick();
        wdt_to_i = 1'b0;
        repeat (2) tick();
        check(core_rst_o == 1'b1, {req, " R8 core_rst raised"}, core_rst_o, 1);
        ms = 1'b0;
        repeat (12) tick();
        chk_state(req);
    endtask

    task automatic do_write(input logic [7:0] d);
        if (!ms) begin
            m[7:5] = d[7:5];
            m[2:0] = d[2:0];
        end
        wr_en_i = 1'b1; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
        chk_state(ms ? "R10 write while sleeping" : "R9 write");
    endtask

    task automatic do_strobes(input logic s, input logic w);
        if (!ms) begin
            if (s) begin m[4:3] = 2'b10; ms = 1'b1; end
            else if (w) m[4:3] = 2'b11;
        end
        sleep_i = s; wdt_clr_i = w;
        tick();
        sleep_i = 1'b0; wdt_clr_i = 1'b0;
        chk_state("R7 strobe");
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd1234);
        m = 8'h00;
        ms = 1'b0;
        @(negedge clk);

        // R1 reset state
        do_por(3);
        // R9: write tries all bits; flags stay
        do_write(8'hA5);
        check(status_o == 8'hBD, "R9 write A5", status_o, 8'hBD);
        do_write(8'h00);
        // R4 watchdog awake
        do_write(8'hA5);
        do_wdt("R4 wdt awake");
        check(status_o == 8'h0D, "R4 value", status_o, 8'h0D);
        // R2 clear awake
        do_write(8'hE0 | 8'h05);
        do_clr(4, 1'b0, "R2 clear awake");
        check(status_o == 8'h0D, "R2 value", status_o, 8'h0D);
        // R7 sleep, R10 ignored write, R5 wdt while sleeping
        do_write(8'hE2);
        do_strobes(1'b1, 1'b0);
        check(status_o == 8'hF2, "R7 sleep value", status_o, 8'hF2);
        do_write(8'h07);
        do_strobes(1'b0, 1'b1);
        do_wdt("R5 wdt sleeping");
        check(status_o == 8'h02, "R5 value", status_o, 8'h02);
        // R7 watchdog clear, R3 clear while sleeping
        do_strobes(1'b0, 1'b1);
        check(status_o == 8'h1A, "R7 wdt clear value", status_o, 8'h1A);
        do_strobes(1'b1, 1'b0);
        do_clr(5, 1'b0, "R3 clear sleeping");
        check(status_o == 8'h12, "R3 value", status_o, 8'h12);
        // R10 write and strobe during core reset
        do_clr(6, 1'b1, "R10 write during reset");
        // R7 both strobes: sleep wins
        do_strobes(1'b1, 1'b1);
        check(status_o[4:3] == 2'b10, "R7 sleep beats wdt clear", status_o[4:3], 2);
        // R6 clear and watchdog together while sleeping
        m = model_rst(m, 1, ms);
        clr_n_i = 1'b0; wdt_to_i = 1'b1;
        tick();
        wdt_to_i = 1'b0;
        repeat (3) tick();
        clr_n_i = 1'b1;
        ms = 1'b0;
        repeat (14) tick();
        chk_state("R6 clear beats watchdog");
        check(status_o[4:3] == 2'b10, "R6 flags", status_o[4:3], 2);
        // R6 power-on overlapping clear and watchdog
        do_write(8'hE7);
        do_wdt("R4 pre");
        por_i = 1'b1; clr_n_i = 1'b0; wdt_to_i = 1'b1;
        tick();
        clr_n_i = 1'b1; wdt_to_i = 1'b0;
        repeat (4) tick();
        por_i = 1'b0;
        m = 8'h18; ms = 1'b0;
        repeat (10) tick();
        chk_state("R6 power-on beats others");

        // constrained random
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2: do_write(8'($urandom));
                3:       do_strobes(1'b1, 1'($urandom_range(0, 1)));
                4:       do_strobes(1'b0, 1'b1);
                5, 6:    do_clr($urandom_range(3, 6), 1'($urandom_range(0, 1)), "R2 R3 random clear");
                7, 8:    do_wdt("R4 R5 random wdt");
                default: begin
                    if ($urandom_range(0, 3) == 0) do_por($urandom_range(1, 4));
                    else begin tick(); chk_state("R10 idle"); end
                end
            endcase
        end
        finish_run();
    end
endmodule